// File: doc/BRIEF.md
# Flash Status Read Path

This block forms the byte returned by every read of a byte-wide flash memory model. Most of the time it simply forwards the byte supplied by the storage array. While the memory controller reports an internal program or erase, it returns end-of-write status instead. During a program, bit 7 holds the inverse of the bit being written. During an erase, bit 7 reads 0. In both cases bit 6 changes value on every read. When a program finishes, bit 7 shows its final value first, and the rest of the byte stays masked for a programmable number of clock cycles. When the controller selects identification mode, reads at two fixed addresses return a vendor byte and a density-dependent device byte.

Everything runs in one clock domain. A read is registered. Its result appears one clock after the strobe, together with a valid flag. The valid flag stands in for the tri-state bus. It is only raised when both active-low enables were asserted with the strobe. Array storage and command decoding are done elsewhere.

Top module: `flash_status_rd`

## Requirements
- R1: While `busy` is 1 and the operation is a program (`op_is_erase`=0), bit 7 of a read result is the inverse of the `prog_msb` value captured when the operation began.
- R2: While `busy` is 1 and the operation is an erase (`op_is_erase`=1), bit 7 of a read result is 0. After the erase ends, reads return `arr_data` unchanged, so an erased location reads bit 7 = 1.
- R3: During an operation, bit 6 of successive enabled reads alternates. The first enabled read of each operation returns bit 6 = 0.
- R4: The bit-6 state restarts at 0 at the cycle in which `busy` rises, including after an earlier operation left it at 1. A cycle without an enabled read does not advance it.
- R5: While `busy` is 1, bits 5..0 of a read result are 0 and `arr_data` never appears, even when `id_mode` is 1.
- R6: The operation type and `prog_msb` are sampled only in the cycle in which `busy` rises. Changes to them during the operation have no effect.
- R7: After a program ends, reads return {captured bit 7, 7'b0} for SETTLE_CYC cycles, counted from the cycle in which `busy` falls. After that, reads return array data. An erase end has no such window.
- R8: When not busy and not settling, with `id_mode`=1: address 0 returns 8'hBF, address 1 returns 8'hD4+DENSITY (DENSITY 0..3), and any other address returns 8'h00.
- R9: A read is enabled when `rd_stb`=1, `ce_n`=0 and `oe_n`=0. One cycle later `dout_vld`=1 and `dout` carries the result. After any other cycle `dout_vld`=0 and `dout`=8'h00.
- R10: After reset, `dout_vld`=0, `dout`=8'h00, no settle window is open, and bit-6 state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one per read |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address of the read |
| arr_data | input | 8 | Byte from the storage array |
| busy | input | 1 | Internal program or erase in progress |
| op_is_erase | input | 1 | Operation type: 1 erase, 0 program |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| id_mode | input | 1 | Identification mode selected |
| dout | output | 8 | Read result, 0 when not valid |
| dout_vld | output | 1 | Result is driven (models the output buffer) |

## Verification
Internal state shows up only through the bytes returned by reads. A bit-6 register that has gone stale or fails to restart shows as a repeated or inverted bit 6 on the first or second status read of an operation. A wrong latched operation type or data bit flips bit 7 on the very next status read. A settle counter that is off by one exposes array data one cycle early, or masks it one cycle too long, at the end of the window. A bench model that is compared on every clock therefore catches each of these within one read of its cause.

// File: rtl/fsr_pkg.sv
// Shared types and constants of the flash status read path.
package fsr_pkg;
    typedef enum logic {OPK_PROG = 1'b0, OPK_ERASE = 1'b1} op_kind_e;
    localparam logic [7:0] MFR_CODE      = 8'hBF;
    localparam logic [7:0] DEV_CODE_BASE = 8'hD4;
endpackage

// File: rtl/fsr_op_track.sv
// Tracks the internal write operation: detects its start and end, captures
// the operation kind and programmed bit 7 at start, and times the settle
// window after a program. Assumes busy is synchronous to clk.
module fsr_op_track
    import fsr_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy,
    input  logic     op_is_erase,
    input  logic     prog_msb,
    output logic     op_start,
    output op_kind_e kind_eff,
    output logic     b7_eff,
    output logic     settling
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic             busy_q;
    op_kind_e         kind_q;
    logic             b7_q;
    logic [CNT_W-1:0] cnt_q;
    logic             op_end;

    // Edge detection and same-cycle forwarding of captured values.
    always_comb begin
        op_start = busy & ~busy_q;
        op_end   = ~busy & busy_q;
        kind_eff = op_start ? op_kind_e'(op_is_erase) : kind_q;
        b7_eff   = op_start ? prog_msb : b7_q;
        settling = (op_end & (kind_q == OPK_PROG)) | (cnt_q != '0);
    end

    // Capture of operation attributes and settle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= OPK_PROG;
            b7_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy;
            if (op_start) begin
                kind_q <= op_kind_e'(op_is_erase);
                b7_q   <= prog_msb;
            end
            if (op_start)
                cnt_q <= '0;
            else if (op_end && kind_q == OPK_PROG)
                cnt_q <= LOAD_VAL;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL); // R7
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !op_start |=> kind_q == $past(kind_q) && b7_q == $past(b7_q)); // R6
endmodule

// File: rtl/fsr_toggle.sv
// Bit-6 toggle state. It restarts at 0 when an operation begins and
// advances only on enabled reads during the operation.
module fsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic busy,
    input  logic rd_en,
    output logic tgl_now
);
    logic tgl_q;

    // Value returned by a read in this cycle.
    assign tgl_now = op_start ? 1'b0 : tgl_q;

    // Restart at operation start, flip after each enabled status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgl_q <= 1'b0;
        else if (op_start)
            tgl_q <= rd_en;
        else if (busy && rd_en)
            tgl_q <= ~tgl_q;
    end

    AST_TGL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && !rd_en |=> !tgl_q); // R4
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !op_start |=> $stable(tgl_q)); // R4
endmodule

// File: rtl/fsr_id_rom.sv
// Identification byte generator: vendor code at address 0, density-coded
// device byte at address 1, zero elsewhere. Assumes DENSITY is 0..3.
module fsr_id_rom
    import fsr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DENSITY = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        id_byte
);
    localparam logic [7:0] DEV_CODE = DEV_CODE_BASE + 8'(DENSITY);

    // Address decode of the two identification locations.
    always_comb begin
        if (addr == ADDR_W'(0))
            id_byte = MFR_CODE;
        else if (addr == ADDR_W'(1))
            id_byte = DEV_CODE;
        else
            id_byte = 8'h00;
    end
endmodule

// File: rtl/flash_status_rd.sv
// Read-data output stage of a byte-wide flash model. Selects status bits,
// the settling byte, an identification byte or array data, and registers
// the result with a valid flag. Assumes all inputs are synchronous to clk.
module flash_status_rd
    import fsr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DENSITY    = 0,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        arr_data,
    input  logic              busy,
    input  logic              op_is_erase,
    input  logic              prog_msb,
    input  logic              id_mode,
    output logic [7:0]        dout,
    output logic              dout_vld
);
    logic     rd_en;
    logic     op_start;
    op_kind_e kind_eff;
    logic     b7_eff;
    logic     settling;
    logic     tgl_now;
    logic [7:0] id_byte;
    logic [7:0] sel_byte;
    logic [7:0] dout_q;
    logic       vld_q;

    assign rd_en = rd_stb & ~ce_n & ~oe_n;

    fsr_op_track #(.SETTLE_CYC(SETTLE_CYC)) u_track (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_is_erase(op_is_erase),
        .prog_msb(prog_msb), .op_start(op_start), .kind_eff(kind_eff),
        .b7_eff(b7_eff), .settling(settling)
    );

    fsr_toggle u_tgl (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .busy(busy),
        .rd_en(rd_en), .tgl_now(tgl_now)
    );

    fsr_id_rom #(.ADDR_W(ADDR_W), .DENSITY(DENSITY)) u_id (
        .addr(addr), .id_byte(id_byte)
    );

    // Source selection in priority order: status, settle, ID, array.
    always_comb begin
        if (busy)
            sel_byte = {(kind_eff == OPK_ERASE) ? 1'b0 : ~b7_eff, tgl_now, 6'b0};
        else if (settling)
            sel_byte = {b7_eff, 7'b0};
        else if (id_mode)
            sel_byte = id_byte;
        else
            sel_byte = arr_data;
    end

    // Output register: result and valid flag one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 8'h00;
            vld_q  <= 1'b0;
        end else begin
            dout_q <= rd_en ? sel_byte : 8'h00;
            vld_q  <= rd_en;
        end
    end

    assign dout     = dout_q;
    assign dout_vld = vld_q;

    AST_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && !ce_n && !oe_n) |=> !dout_vld && dout == 8'h00); // R9
    AST_BUSY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy |=> dout[5:0] == 6'b0); // R5
    AST_ERASE_B7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy && op_start && op_is_erase |=> !dout[7]); // R2
    AST_PROG_B7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy && op_start && !op_is_erase |=> dout[7] == !$past(prog_msb)); // R1
    AST_SETTLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !busy && settling |=> dout[6:0] == 7'b0); // R7
    AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !busy && !settling && id_mode && addr == ADDR_W'(0)
        |=> dout == MFR_CODE); // R8
endmodule

// File: tb/tb_flash_status_rd.sv
module tb_flash_status_rd;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DENSITY    = 2;
    localparam int SETTLE     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] arr_data = 8'h00;
    logic busy = 1'b0, op_is_erase = 1'b0, prog_msb = 1'b0, id_mode = 1'b0;
    logic [7:0] dout;
    logic dout_vld;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state.
    bit m_bq = 0, m_erase = 0, m_b7 = 0, m_tgl = 0;
    int m_left = 0;

    flash_status_rd #(.ADDR_W(ADDR_W), .DENSITY(DENSITY), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .arr_data(arr_data), .busy(busy), .op_is_erase(op_is_erase),
        .prog_msb(prog_msb), .id_mode(id_mode), .dout(dout), .dout_vld(dout_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One clock: predict from current inputs, advance, compare.
    task automatic step(input string tag);
        bit rd, start, fall;
        logic [7:0] ex, e_d;
        bit e_v;
        rd = rd_stb && !ce_n && !oe_n;
        if (!rst_n) begin
            m_bq = 0; m_erase = 0; m_b7 = 0; m_tgl = 0; m_left = 0;
            e_d = 8'h00; e_v = 0;
        end else begin
            start = busy && !m_bq;
            fall  = !busy && m_bq;
            if (start) begin
                m_erase = op_is_erase; m_b7 = prog_msb; m_tgl = 0; m_left = 0;
            end
            if (fall && !m_erase) m_left = SETTLE;
            if (busy) begin
                ex = {m_erase ? 1'b0 : !m_b7, m_tgl, 6'b0};
                if (rd) m_tgl = !m_tgl;
            end else if (m_left > 0)
                ex = {m_b7, 7'b0};
            else if (id_mode)
                ex = (addr == 0) ? 8'hBF : (addr == 1) ? 8'hD4 + DENSITY : 8'h00;
            else
                ex = arr_data;
            e_d = rd ? ex : 8'h00;
            e_v = rd;
            if (m_left > 0) m_left--;
            m_bq = busy;
        end
        @(posedge clk);
        #1;
        total++;
        if (dout !== e_d || dout_vld !== e_v) begin
            bad++;
            $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
                     tag, dout, dout_vld, e_d, e_v);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        rd_stb = 1; ce_n = 0; oe_n = 0; addr = a;
        step(tag);
        rd_stb = 0; ce_n = 1; oe_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        for (int i = 0; i < 3; i++) step("R10 reset");
        rst_n = 1;
        step("R10 idle after reset");
        // Array reads and enable gating.
        arr_data = 8'h5A; rd(16'h0123, "R9 array read");
        arr_data = 8'hC3; rd(16'h0001, "R9 array read 2");
        rd_stb = 1; ce_n = 1; oe_n = 0; step("R9 chip disabled");
        ce_n = 0; oe_n = 1; step("R9 output disabled");
        rd_stb = 0; oe_n = 0; step("R9 no strobe");
        ce_n = 1; oe_n = 1;
        // Identification mode.
        id_mode = 1;
        rd(16'h0000, "R8 vendor byte");
        rd(16'h0001, "R8 device byte");
        rd(16'h0002, "R8 other address");
        id_mode = 0;
        // Program with a read in the starting cycle.
        prog_msb = 1; op_is_erase = 0; busy = 1;
        rd(16'h0010, "R4 first read at start");
        rd(16'h0010, "R1 R3 program status");
        rd_stb = 1; ce_n = 1; step("R4 disabled read no advance");
        rd_stb = 0;
        rd(16'h0010, "R3 toggle");
        prog_msb = 0; op_is_erase = 1; id_mode = 1;
        rd(16'h0000, "R6 capture hold");
        rd(16'h0001, "R5 status over id");
        id_mode = 0; arr_data = 8'hA7;
        busy = 0;
        for (int i = 0; i < SETTLE + 2; i++) rd(16'h0010, "R7 settle window");
        // Erase.
        op_is_erase = 1; busy = 1; step("R4 start without read");
        for (int i = 0; i < 4; i++) rd(16'h2000, "R2 R3 erase status");
        busy = 0; arr_data = 8'hFF;
        rd(16'h2000, "R2 erase done");
        rd(16'h2001, "R2 erase done no settle");
        // Program, then a new op starting inside the settle window.
        prog_msb = 0; op_is_erase = 0; busy = 1;
        rd(16'h0040, "R1 program zero");
        busy = 0; rd(16'h0040, "R7 settle first");
        rd(16'h0040, "R7 settle second");
        op_is_erase = 1; busy = 1;
        rd(16'h0040, "R4 restart in settle");
        rd(16'h0040, "R2 erase after program");
        busy = 0; arr_data = 8'h3C;
        rd(16'h0040, "R2 array after erase");
        // Mixed pattern sweep.
        for (int i = 0; i < 120; i++) begin
            rd_stb = (i % 3) != 1; ce_n = (i % 7) == 5; oe_n = (i % 11) == 4;
            addr = ADDR_W'(i % 4); arr_data = 8'(i * 37 + 11);
            id_mode = (i % 5) < 2; prog_msb = i[3];
            op_is_erase = (i % 13) > 8;
            busy = (i % 17) < 9;
            step("R5 mixed sweep");
        end
        rd_stb = 0; ce_n = 1; oe_n = 1; busy = 0;
        for (int i = 0; i < SETTLE + 2; i++) step("R9 drain");
        rst_n = 0; step("R10 reset again");
        rst_n = 1; rd(16'h0003, "R10 after second reset");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule